// File: doc/BRIEF.md
# VT Path Overhead (V5) Byte Generator

This block sits in the transmit path of one low-order virtual tributary (VT1.5 / TU-11 style) and rewrites the path overhead byte of each VT superframe as it goes by. The tributary arrives one byte per clock, with a qualifier. Two marker inputs flag the path overhead byte position and the four pointer byte positions. Every byte leaves one clock later. The overhead byte is rebuilt from five fields: a BIP-2 parity pair over the previous superframe, a remote error bit, a remote failure bit, a 3-bit signal label, and a remote defect bit.

Each status field takes its value from one of three places, chosen by mode. It can be computed from receive-side status inputs, taken from a stored copy of the received overhead when protection-switch mode is on, or set by hand (remote failure only). Three overrides act on whole bytes. Loopback passes every byte untouched. Forced alarm (AIS-V) turns every byte into all ones, pointer bytes included. Two error-injection modes corrupt the parity pair.

A small controller tracks whether a superframe boundary has been seen. Its states are:
- HUNT: after reset, or after an override is released.
- RUN: the parity is being accumulated.
- LOOP: loopback is active.
- AIS: forced alarm is active.

Its transitions are:
- any state to LOOP while loopback is requested;
- any state to AIS while forced alarm is requested without loopback;
- HUNT, LOOP or AIS to RUN on an overhead byte when neither override is requested;
- HUNT, LOOP or AIS to HUNT on any other cycle without an override;
- RUN stays in RUN.

Top module: `vtoh_v5_gen`

## Requirements
- R1: Output data and the qualifier appear one clock after input. Reset drives both to zero. Bytes that are not a generated overhead byte pass unchanged, pointer bytes included.
- R2: While loopback is requested, every byte passes unchanged, the overhead byte included. Loopback wins over forced alarm.
- R3: The overhead byte is laid out with data bit 7 as bit 1, giving [7:6] parity pair, [5] remote error, [4] remote failure, [3:1] signal label, [0] remote defect. The label equals map type bits [2:0] for map types 0 to 7, and is 001 for map types 8 to 15.
- R4: Map type 0 yields the unequipped label 000.
- R5: While forced alarm is requested and loopback is not, every valid output byte is 0xFF. This includes pointer bytes and overhead bytes.
- R6: Parity bit [7] is even parity over bits 7, 5, 3, 1 of every transmitted non-pointer byte, from the previous overhead byte (inclusive) up to the current one. Parity bit [6] covers bits 6, 4, 2, 0. The first overhead byte after reset or after an override is released carries 00.
- R7: Error mode 01 inverts both parity bits of every overhead byte. Mode 10 inverts them once at the next overhead byte after each rising edge of the error strobe. Modes 00 and 11 leave the parity intact.
- R8: Remote error is 0 unless remote-error enable is set. With the enable set, it equals stored bit [2] in protection mode, and otherwise the receive-side parity-error input.
- R9: Remote failure equals the manual value when manual enable is set. Otherwise it equals stored bit [1] in protection mode. Otherwise it equals the receive-side failure input.
- R10: When the map type is 4 (byte-synchronous) and neither manual nor protection mode applies, the framer remote-alarm input also sets remote failure.
- R11: Remote defect equals stored bit [0] in protection mode. Otherwise it is the OR of the loss-of-pointer and alarm inputs, sampled at the overhead byte.
- R12: In protection mode, the parity pair and the signal label are still generated as in R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| trib_data_i | input | 8 | tributary byte in |
| trib_valid_i | input | 1 | input byte qualifier |
| v5_mark_i | input | 1 | current byte is the path overhead byte |
| ptr_mark_i | input | 1 | current byte is one of the four pointer bytes |
| loopback_i | input | 1 | pass everything unchanged |
| ais_force_i | input | 1 | overwrite every byte with ones |
| prot_mode_i | input | 1 | protection-switch mode |
| map_type_i | input | 4 | mapping type selecting the label |
| bip_err_mode_i | input | 2 | parity error injection mode |
| err_strobe_i | input | 1 | global one-shot injection strobe |
| rei_en_i | input | 1 | remote error enable |
| rfi_man_en_i | input | 1 | manual remote failure enable |
| rfi_man_val_i | input | 1 | manual remote failure value |
| rx_ovh_i | input | 3 | stored received fields {error, failure, defect} |
| rx_bip_err_i | input | 1 | receive side saw parity errors |
| rx_rfi_fault_i | input | 1 | receive-side failure status |
| rx_lop_i | input | 1 | receive-side loss of pointer |
| rx_aisv_i | input | 1 | receive-side alarm detected |
| ds1_rai_i | input | 1 | framer remote alarm indication |
| trib_data_o | output | 8 | tributary byte out |
| trib_valid_o | output | 1 | output byte qualifier |

## Verification
The parity pair is tested with a hand-computed superframe. That superframe mixes data bytes with a pointer byte, which shows whether pointer bytes are wrongly counted and whether the previous overhead byte is left out. Later frames are compared against a running parity of the observed output bytes. Each source of the three status bits is driven with the other sources set to the opposite value, so the chosen priority becomes visible. The overrides are given pointer and overhead bytes with contrasting contents, together with the first frame after release, to separate a clean restart from stale parity.

// File: rtl/vtoh_pkg.sv
package vtoh_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAP_W   = 4;
    localparam int LABEL_W = 3;

    typedef enum logic [1:0] {ST_HUNT, ST_RUN, ST_LOOP, ST_AIS} vt_state_e;
    typedef enum logic [1:0] {SEL_PASS, SEL_ONES, SEL_V5} out_sel_e;
    typedef enum logic [1:0] {ACC_HOLD, ACC_CLR, ACC_LOAD, ACC_ADD} acc_op_e;

    typedef struct packed {
        logic [1:0]         bip;
        logic               rei;
        logic               rfi;
        logic [LABEL_W-1:0] label;
        logic               rdi;
    } v5_t;

    // parity pair: odd-numbered bits (7,5,3,1) and even-numbered bits (6,4,2,0)
    function automatic logic [1:0] bip_fold(input logic [BYTE_W-1:0] acc);
        logic p_hi;
        logic p_lo;
        p_hi = 1'b0;
        p_lo = 1'b0;
        for (int i = 0; i < BYTE_W; i += 2) begin
            p_hi ^= acc[i+1];
            p_lo ^= acc[i];
        end
        return {p_hi, p_lo};
    endfunction
endpackage

// File: rtl/vtoh_ctrl.sv
module vtoh_ctrl
    import vtoh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid_i,
    input  logic     v5_i,
    input  logic     ptr_i,
    input  logic     loop_i,
    input  logic     ais_i,
    output out_sel_e sel_o,
    output acc_op_e  acc_op_o
);
    vt_state_e state_q;
    vt_state_e state_n;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        if (loop_i) begin
            state_n = ST_LOOP;
        end else if (ais_i) begin
            state_n = ST_AIS;
        end else begin
            unique case (state_q)
                ST_RUN:                    state_n = ST_RUN;
                ST_HUNT, ST_LOOP, ST_AIS:  state_n = (valid_i && v5_i) ? ST_RUN : ST_HUNT;
            endcase
        end
    end

    always_comb begin
        sel_o    = SEL_PASS;
        acc_op_o = ACC_HOLD;
        if (loop_i) begin
            sel_o    = SEL_PASS;
            acc_op_o = ACC_CLR;
        end else if (ais_i) begin
            sel_o    = SEL_ONES;
            acc_op_o = ACC_CLR;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (valid_i && v5_i) begin
                        sel_o    = SEL_V5;
                        acc_op_o = ACC_LOAD;
                    end else if (valid_i && !ptr_i) begin
                        acc_op_o = ACC_ADD;
                    end
                end
                ST_HUNT, ST_LOOP, ST_AIS: begin
                    if (valid_i && v5_i) begin
                        sel_o    = SEL_V5;
                        acc_op_o = ACC_LOAD;
                    end else begin
                        acc_op_o = ACC_CLR;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vtoh_bip.sv
module vtoh_bip
    import vtoh_pkg::*;
#(
    parameter logic [1:0] MODE_CONT = 2'b01,
    parameter logic [1:0] MODE_ONCE = 2'b10
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           acc_op_i,
    input  logic [BYTE_W-1:0] sent_i,
    input  logic              fire_i,
    input  logic [1:0]        err_mode_i,
    input  logic              err_strobe_i,
    output logic [1:0]        bip_o
);
    logic [BYTE_W-1:0] acc_q;
    logic              strobe_q;
    logic              pend_q;
    logic              inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (acc_op_i)
                ACC_HOLD: acc_q <= acc_q;
                ACC_CLR:  acc_q <= '0;
                ACC_LOAD: acc_q <= sent_i;
                ACC_ADD:  acc_q <= acc_q ^ sent_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            strobe_q <= err_strobe_i;
            if (err_mode_i != MODE_ONCE)         pend_q <= 1'b0;
            else if (err_strobe_i && !strobe_q)  pend_q <= 1'b1;
            else if (fire_i)                     pend_q <= 1'b0;
        end
    end

    assign inv   = (err_mode_i == MODE_CONT) || ((err_mode_i == MODE_ONCE) && pend_q);
    assign bip_o = bip_fold(acc_q) ^ {2{inv}};
endmodule

// File: rtl/vtoh_field.sv
module vtoh_field
    import vtoh_pkg::*;
#(
    parameter logic [MAP_W-1:0]   BYTE_SYNC_CODE = 4'd4,
    parameter logic [LABEL_W-1:0] HIGH_MAP_LABEL = 3'b001
) (
    input  logic [1:0]       bip_i,
    input  logic [MAP_W-1:0] map_type_i,
    input  logic             prot_i,
    input  logic             rei_en_i,
    input  logic             rfi_man_en_i,
    input  logic             rfi_man_val_i,
    input  logic [2:0]       rx_ovh_i,
    input  logic             rx_bip_err_i,
    input  logic             rx_rfi_fault_i,
    input  logic             rx_lop_i,
    input  logic             rx_aisv_i,
    input  logic             ds1_rai_i,
    output v5_t              v5_o
);
    logic byte_sync;
    logic auto_rfi;

    assign byte_sync = (map_type_i == BYTE_SYNC_CODE);
    assign auto_rfi  = rx_rfi_fault_i || (byte_sync && ds1_rai_i);

    always_comb begin
        v5_o.bip   = bip_i;
        v5_o.label = map_type_i[MAP_W-1] ? HIGH_MAP_LABEL : map_type_i[LABEL_W-1:0];
        v5_o.rei   = rei_en_i && (prot_i ? rx_ovh_i[2] : rx_bip_err_i);
        if (rfi_man_en_i) v5_o.rfi = rfi_man_val_i;
        else if (prot_i)  v5_o.rfi = rx_ovh_i[1];
        else              v5_o.rfi = auto_rfi;
        v5_o.rdi   = prot_i ? rx_ovh_i[0] : (rx_lop_i || rx_aisv_i);
    end
endmodule

// File: rtl/vtoh_v5_gen.sv
module vtoh_v5_gen
    import vtoh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  trib_data_i,
    input  logic        trib_valid_i,
    input  logic        v5_mark_i,
    input  logic        ptr_mark_i,
    input  logic        loopback_i,
    input  logic        ais_force_i,
    input  logic        prot_mode_i,
    input  logic [3:0]  map_type_i,
    input  logic [1:0]  bip_err_mode_i,
    input  logic        err_strobe_i,
    input  logic        rei_en_i,
    input  logic        rfi_man_en_i,
    input  logic        rfi_man_val_i,
    input  logic [2:0]  rx_ovh_i,
    input  logic        rx_bip_err_i,
    input  logic        rx_rfi_fault_i,
    input  logic        rx_lop_i,
    input  logic        rx_aisv_i,
    input  logic        ds1_rai_i,
    output logic [7:0]  trib_data_o,
    output logic        trib_valid_o
);
    out_sel_e          sel;
    acc_op_e           acc_op;
    logic [1:0]        bip;
    v5_t               v5_word;
    logic [BYTE_W-1:0] sent;
    logic              fire;

    vtoh_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (trib_valid_i),
        .v5_i     (v5_mark_i),
        .ptr_i    (ptr_mark_i),
        .loop_i   (loopback_i),
        .ais_i    (ais_force_i),
        .sel_o    (sel),
        .acc_op_o (acc_op)
    );

    assign fire = (sel == SEL_V5);

    vtoh_bip u_bip (
        .clk          (clk),
        .rst          (rst),
        .acc_op_i     (acc_op),
        .sent_i       (sent),
        .fire_i       (fire),
        .err_mode_i   (bip_err_mode_i),
        .err_strobe_i (err_strobe_i),
        .bip_o        (bip)
    );

    vtoh_field u_field (
        .bip_i          (bip),
        .map_type_i     (map_type_i),
        .prot_i         (prot_mode_i),
        .rei_en_i       (rei_en_i),
        .rfi_man_en_i   (rfi_man_en_i),
        .rfi_man_val_i  (rfi_man_val_i),
        .rx_ovh_i       (rx_ovh_i),
        .rx_bip_err_i   (rx_bip_err_i),
        .rx_rfi_fault_i (rx_rfi_fault_i),
        .rx_lop_i       (rx_lop_i),
        .rx_aisv_i      (rx_aisv_i),
        .ds1_rai_i      (ds1_rai_i),
        .v5_o           (v5_word)
    );

    always_comb begin
        unique case (sel)
            SEL_PASS: sent = trib_data_i;
            SEL_ONES: sent = '1;
            SEL_V5:   sent = v5_word;
            default:  sent = trib_data_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trib_data_o  <= '0;
            trib_valid_o <= 1'b0;
        end else begin
            trib_data_o  <= sent;
            trib_valid_o <= trib_valid_i;
        end
    end
endmodule

// File: rtl/vtoh_v5_chk.sv
module vtoh_v5_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] trib_data_i,
    input logic       trib_valid_i,
    input logic       v5_mark_i,
    input logic       ptr_mark_i,
    input logic       loopback_i,
    input logic       ais_force_i,
    input logic       prot_mode_i,
    input logic [3:0] map_type_i,
    input logic       rei_en_i,
    input logic       rfi_man_en_i,
    input logic [2:0] rx_ovh_i,
    input logic [7:0] trib_data_o,
    input logic       trib_valid_o
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        trib_valid_i |=> trib_valid_o);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !trib_valid_i |=> !trib_valid_o);
    // R1
    ptr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && ptr_mark_i && !loopback_i && !ais_force_i)
        |=> trib_data_o == $past(trib_data_i));
    // R2
    loop_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && loopback_i) |=> trib_data_o == $past(trib_data_i));
    // R5
    ais_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && ais_force_i && !loopback_i) |=> trib_data_o == 8'hFF);
    // R4
    uneq_label_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && v5_mark_i && !loopback_i && !ais_force_i && map_type_i == 4'd0)
        |=> trib_data_o[3:1] == 3'b000);
    // R8
    rei_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && v5_mark_i && !loopback_i && !ais_force_i && prot_mode_i && rei_en_i)
        |=> trib_data_o[5] == $past(rx_ovh_i[2]));
    // R9
    rfi_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && v5_mark_i && !loopback_i && !ais_force_i && prot_mode_i && !rfi_man_en_i)
        |=> trib_data_o[4] == $past(rx_ovh_i[1]));
    // R11
    rdi_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (trib_valid_i && v5_mark_i && !loopback_i && !ais_force_i && prot_mode_i)
        |=> trib_data_o[0] == $past(rx_ovh_i[0]));
endmodule

bind vtoh_v5_gen vtoh_v5_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .trib_data_i  (trib_data_i),
    .trib_valid_i (trib_valid_i),
    .v5_mark_i    (v5_mark_i),
    .ptr_mark_i   (ptr_mark_i),
    .loopback_i   (loopback_i),
    .ais_force_i  (ais_force_i),
    .prot_mode_i  (prot_mode_i),
    .map_type_i   (map_type_i),
    .rei_en_i     (rei_en_i),
    .rfi_man_en_i (rfi_man_en_i),
    .rx_ovh_i     (rx_ovh_i),
    .trib_data_o  (trib_data_o),
    .trib_valid_o (trib_valid_o)
);

// File: tb/vtoh_v5_gen_test.sv
module vtoh_v5_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic       vin = 1'b0, v5m = 1'b0, ptrm = 1'b0;
    logic       loop = 1'b0, ais = 1'b0, prot = 1'b0;
    logic [3:0] map = 4'd2;
    logic [1:0] emode = 2'b00;
    logic       estb = 1'b0, rei_en = 1'b0, man_en = 1'b0, man_val = 1'b0;
    logic [2:0] ovh = 3'b000;
    logic       bip_err = 1'b0, fault = 1'b0, lop = 1'b0, aisv = 1'b0, rai = 1'b0;
    logic [7:0] dout;
    logic       vout;

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] m_acc = '0;
    bit         m_sync = 1'b0;
    logic [7:0] q;
    logic [1:0] eb;

    always #2.5ns clk = ~clk;

    vtoh_v5_gen uut (
        .clk(clk), .rst(rst), .trib_data_i(din), .trib_valid_i(vin),
        .v5_mark_i(v5m), .ptr_mark_i(ptrm), .loopback_i(loop), .ais_force_i(ais),
        .prot_mode_i(prot), .map_type_i(map), .bip_err_mode_i(emode),
        .err_strobe_i(estb), .rei_en_i(rei_en), .rfi_man_en_i(man_en),
        .rfi_man_val_i(man_val), .rx_ovh_i(ovh), .rx_bip_err_i(bip_err),
        .rx_rfi_fault_i(fault), .rx_lop_i(lop), .rx_aisv_i(aisv), .ds1_rai_i(rai),
        .trib_data_o(dout), .trib_valid_o(vout)
    );

    function automatic logic [1:0] par2(input logic [7:0] a);
        return {a[7] ^ a[5] ^ a[3] ^ a[1], a[6] ^ a[4] ^ a[2] ^ a[0]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %02h expected %02h", tag, got, exp);
        end
    endtask

    // one byte in, its output captured at the following falling edge
    task automatic send(input logic [7:0] d, input bit is_v5, input bit is_ptr);
        din = d; vin = 1'b1; v5m = is_v5; ptrm = is_ptr;
        @(negedge clk);
        q  = dout;
        eb = m_sync ? par2(m_acc) : 2'b00;
        if (is_v5) begin
            m_acc  = q;
            m_sync = 1'b1;
        end else if (m_sync && !is_ptr) begin
            m_acc ^= q;
        end
        v5m = 1'b0; ptrm = 1'b0;
    endtask

    task automatic idle(input int n);
        vin = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic resync();
        m_acc  = '0;
        m_sync = 1'b0;
    endtask

    // a short superframe: data, pointer, data, then the overhead byte
    task automatic frame(input logic [7:0] d);
        send(d, 0, 0);
        send(8'hA5, 0, 1);
        send(~d, 0, 0);
        send(8'h00, 1, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset data", dout, 8'h00);
        chk("R1 reset valid", {7'd0, vout}, 8'h00);
    endtask

    task automatic t_pass();
        send(8'h5A, 0, 0);
        chk("R1 data pass", q, 8'h5A);
        chk("R1 valid follows", {7'd0, vout}, 8'h01);
        send(8'hC3, 0, 1);
        chk("R1 pointer pass", q, 8'hC3);
    endtask

    task automatic t_bip();
        map = 4'd2;
        send(8'h00, 1, 0);
        chk("R6 R3 first overhead", q, 8'h04);
        send(8'h81, 0, 0);
        send(8'h3C, 0, 0);
        send(8'h77, 0, 1);
        send(8'h00, 1, 0);
        chk("R6 hand parity", q, 8'h84);
    endtask

    task automatic t_labels();
        map = 4'd0;
        frame(8'h13);
        chk("R4 unequipped label", {5'd0, q[3:1]}, 8'h00);
        chk("R6 parity", {6'd0, q[7:6]}, {6'd0, eb});
        map = 4'd9;
        frame(8'hE7);
        chk("R3 high map label", {5'd0, q[3:1]}, 8'h01);
        map = 4'd6;
        frame(8'h2D);
        chk("R3 label 110", {5'd0, q[3:1]}, 8'h06);
        chk("R6 parity", {6'd0, q[7:6]}, {6'd0, eb});
        map = 4'd2;
    endtask

    task automatic t_errs();
        emode = 2'b01;
        frame(8'h44);
        chk("R7 continuous 1", {6'd0, q[7:6]}, {6'd0, ~eb});
        frame(8'h91);
        chk("R7 continuous 2", {6'd0, q[7:6]}, {6'd0, ~eb});
        emode = 2'b11;
        frame(8'h6E);
        chk("R7 mode 11 clean", {6'd0, q[7:6]}, {6'd0, eb});
        emode = 2'b10;
        frame(8'h0F);
        chk("R7 mode 10 no strobe", {6'd0, q[7:6]}, {6'd0, eb});
        estb = 1'b1;
        idle(2);
        estb = 1'b0;
        frame(8'hB2);
        chk("R7 one-shot fires", {6'd0, q[7:6]}, {6'd0, ~eb});
        frame(8'h58);
        chk("R7 one-shot once", {6'd0, q[7:6]}, {6'd0, eb});
        emode = 2'b00;
    endtask

    task automatic t_rei();
        bip_err = 1'b1; rei_en = 1'b0;
        frame(8'h21);
        chk("R8 disabled", {7'd0, q[5]}, 8'h00);
        rei_en = 1'b1;
        frame(8'h22);
        chk("R8 parity error seen", {7'd0, q[5]}, 8'h01);
        bip_err = 1'b0;
        frame(8'h23);
        chk("R8 no error", {7'd0, q[5]}, 8'h00);
        rei_en = 1'b0;
    endtask

    task automatic t_rfi();
        fault = 1'b1;
        frame(8'h31);
        chk("R9 auto fault", {7'd0, q[4]}, 8'h01);
        fault = 1'b0; map = 4'd4; rai = 1'b1;
        frame(8'h32);
        chk("R10 byte-sync alarm", {7'd0, q[4]}, 8'h01);
        chk("R3 label 100", {5'd0, q[3:1]}, 8'h04);
        map = 4'd3;
        frame(8'h33);
        chk("R10 alarm ignored", {7'd0, q[4]}, 8'h00);
        rai = 1'b0; man_en = 1'b1; man_val = 1'b1;
        frame(8'h34);
        chk("R9 manual one", {7'd0, q[4]}, 8'h01);
        fault = 1'b1; man_val = 1'b0;
        frame(8'h35);
        chk("R9 manual wins", {7'd0, q[4]}, 8'h00);
        fault = 1'b0; man_en = 1'b0; map = 4'd2;
    endtask

    task automatic t_rdi();
        lop = 1'b1;
        frame(8'h41);
        chk("R11 loss of pointer", {7'd0, q[0]}, 8'h01);
        lop = 1'b0; aisv = 1'b1;
        frame(8'h42);
        chk("R11 alarm seen", {7'd0, q[0]}, 8'h01);
        aisv = 1'b0;
        frame(8'h43);
        chk("R11 clear", {7'd0, q[0]}, 8'h00);
    endtask

    task automatic t_prot();
        prot = 1'b1; rei_en = 1'b1; ovh = 3'b111;
        frame(8'h51);
        chk("R12 R8 R9 R11 stored ones", q, {eb, 1'b1, 1'b1, 3'b010, 1'b1});
        ovh = 3'b000; lop = 1'b1; bip_err = 1'b1; fault = 1'b1;
        frame(8'h52);
        chk("R12 R8 R9 R11 stored zeros", q, {eb, 1'b0, 1'b0, 3'b010, 1'b0});
        man_en = 1'b1; man_val = 1'b1;
        frame(8'h53);
        chk("R9 manual over stored", {7'd0, q[4]}, 8'h01);
        prot = 1'b0; rei_en = 1'b0; lop = 1'b0; bip_err = 1'b0; fault = 1'b0;
        man_en = 1'b0; man_val = 1'b0;
    endtask

    task automatic t_ais();
        ais = 1'b1;
        send(8'h12, 0, 1);
        chk("R5 pointer ones", q, 8'hFF);
        send(8'h00, 0, 0);
        chk("R5 data ones", q, 8'hFF);
        send(8'h00, 1, 0);
        chk("R5 overhead ones", q, 8'hFF);
        ais = 1'b0;
        idle(2);
        resync();
        send(8'h11, 0, 0);
        send(8'h00, 1, 0);
        chk("R6 restart parity", {6'd0, q[7:6]}, 8'h00);
    endtask

    task automatic t_loop();
        loop = 1'b1; ais = 1'b1;
        send(8'h5A, 1, 0);
        chk("R2 overhead unchanged", q, 8'h5A);
        send(8'h01, 0, 1);
        chk("R2 pointer unchanged", q, 8'h01);
        send(8'h00, 0, 0);
        chk("R2 over forced alarm", q, 8'h00);
        loop = 1'b0; ais = 1'b0;
        idle(2);
        resync();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_pass();
        t_bip();
        t_labels();
        t_errs();
        t_rei();
        t_rfi();
        t_rdi();
        t_prot();
        t_ais();
        t_loop();
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule